// File: doc/BRIEF.md
# Receive Byte Queue with Threshold Interrupt

This block sits between a serial receiver and the host's read port. Each byte the receiver completes arrives with a one-cycle write strobe. In queued mode the byte enters an eight-slot first-in first-out store. The host sees the oldest byte on the read data output at all times and removes it with a one-cycle read strobe. The block always reports how many bytes it holds. It raises its interrupt request while that count is at or above a threshold that software programs.

In pass-through mode the store is not used. Each received byte lands in a single holding register, which always keeps the newest byte. Software can empty the queue at any time with a flush strobe. A byte that arrives while all eight slots are taken is discarded, and this raises an overflow flag that stays set until the next flush. Host register decoding is left to the surrounding logic.

Top module: `rxq_fifo`

## Requirements
- R1: In queued mode (`en_i`=1) the store holds up to 8 bytes, and `fill_o` never exceeds 8.
- R2: In queued mode `fill_o` equals the number of accepted writes minus the number of effective reads since the store was last emptied.
- R3: Bytes leave the store in the order they were accepted. `rd_data_o` shows the oldest stored byte before it is read.
- R4: In queued mode `irq_o` is 1 exactly when `fill_o` is greater than or equal to the effective trigger level.
- R5: The effective trigger level is 1 when `trig_i` is 0, 8 when `trig_i` is above 8, and `trig_i` otherwise.
- R6: A write while 8 bytes are stored and no read occurs in the same cycle discards the incoming byte and leaves the stored bytes and `fill_o` unchanged. It also sets `ovf_o`, which stays 1 until a flush or a mode change.
- R7: A read and a write in the same cycle on a non-empty store leave `fill_o` unchanged. This holds when the store is full, and in that case `ovf_o` is not set.
- R8: `flush_i` empties the store, the holding register and `ovf_o` on the next edge. It wins over a read or a write in the same cycle.
- R9: In pass-through mode (`en_i`=0) a write loads the byte into the single holding register and overwrites any earlier byte. A read empties the register. `fill_o` is 0 or 1, `irq_o` is 1 while a byte is held, and `rd_data_o` shows the held byte.
- R10: A cycle in which `en_i` differs from its value in the previous cycle acts as a flush. Any write in that cycle is dropped.
- R11: After reset `fill_o`, `irq_o` and `ovf_o` are 0 and the block is in pass-through mode.
- R12: A read strobe while nothing is stored has no effect on `fill_o` or on later read order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | 1 selects queued mode, 0 selects pass-through |
| flush_i | input | 1 | Empty everything and clear overflow |
| wr_i | input | 1 | Receiver byte strobe |
| wr_data_i | input | 8 | Received byte |
| rd_i | input | 1 | Host read strobe |
| trig_i | input | 4 | Interrupt threshold |
| rd_data_o | output | 8 | Oldest byte (queued) or held byte (pass-through) |
| fill_o | output | 4 | Bytes currently held |
| irq_o | output | 1 | Receive interrupt request |
| ovf_o | output | 1 | Sticky overflow error |

## Verification
The bench fills the queue one byte at a time with the threshold at 4. This finds the exact write at which the request turns on. A ninth write into a full queue is then followed by draining it. A surviving ninth byte or any reordering shows up in the read data. Threshold values of 0, 8 and 15 are set against fixed fill counts, so the clamping at each end is told apart from a plain compare. Same-cycle read and write, flush colliding with both strobes, reads on an empty queue, and pass-through overwrite separate the level bookkeeping from the data path and from the mode-switch clearing.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int unsigned RXQ_DATA_W = 8;
    localparam int unsigned RXQ_DEPTH  = 8;

    // Advance a slot index, wrapping after depth-1.
    function automatic int unsigned rxq_step(input int unsigned idx, input int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/rxq_ptrs.sv
module rxq_ptrs
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    localparam int unsigned PW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          push_req_i,
    input  logic          pop_req_i,
    output logic [PW-1:0] wptr_o,
    output logic [PW-1:0] rptr_o,
    output logic [CW-1:0] cnt_o,
    output logic          push_o,
    output logic          ovf_o
);
    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic          ovf;
    } ptr_st_t;

    ptr_st_t st_d, st_q;
    logic    full, empty, pop, push;

    always_comb begin
        full  = (st_q.cnt == CW'(DEPTH));
        empty = (st_q.cnt == '0);
        pop   = pop_req_i && !empty;
        push  = push_req_i && (!full || pop);
        st_d  = st_q;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (push) st_d.wptr = PW'(rxq_step(32'(st_q.wptr), DEPTH));
            if (pop)  st_d.rptr = PW'(rxq_step(32'(st_q.rptr), DEPTH));
            if (push && !pop)      st_d.cnt = st_q.cnt + 1'b1;
            else if (pop && !push) st_d.cnt = st_q.cnt - 1'b1;
            if (push_req_i && !push) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wptr_o = st_q.wptr;
    assign rptr_o = st_q.rptr;
    assign cnt_o  = st_q.cnt;
    assign push_o = push && !clr_i;
    assign ovf_o  = st_q.ovf;

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full && push_req_i && !pop_req_i && !clr_i |=> st_q.cnt == CW'(DEPTH) && st_q.ovf);
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf && !clr_i |=> st_q.ovf);
    p_rdwr_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_req_i && pop_req_i && !empty && !clr_i |=> $stable(st_q.cnt));
    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> st_q.cnt == '0 && !st_q.ovf);
endmodule

// File: rtl/rxq_mem.sv
module rxq_mem
    import rxq_pkg::*;
#(
    parameter int unsigned DW    = RXQ_DATA_W,
    parameter int unsigned DEPTH = RXQ_DEPTH,
    localparam int unsigned PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [PW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [PW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DW-1:0] slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (we_i && (waddr_i == PW'(g))) slot_d = wdata_i;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d;
        end
    end

    assign rdata_o = slot_q[raddr_i];
endmodule

// File: rtl/rxq_level.sv
module rxq_level
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] trig_i,
    input  logic [CW-1:0] cnt_i,
    output logic          irq_o
);
    logic [CW-1:0] eff;

    always_comb begin
        if (trig_i == '0)               eff = CW'(1);
        else if (trig_i > CW'(DEPTH))   eff = CW'(DEPTH);
        else                            eff = trig_i;
        irq_o = (cnt_i >= eff);
    end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DW    = RXQ_DATA_W,
    parameter int unsigned DEPTH = RXQ_DEPTH,
    localparam int unsigned PW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          flush_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_i,
    input  logic [CW-1:0] trig_i,
    output logic [DW-1:0] rd_data_o,
    output logic [CW-1:0] fill_o,
    output logic          irq_o,
    output logic          ovf_o
);
    typedef struct packed {
        logic          en;
        logic [DW-1:0] hold;
        logic          hval;
    } top_st_t;

    top_st_t       st_d, st_q;
    logic          clr;
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          push, lvl_irq;
    logic [DW-1:0] q_data;

    always_comb begin
        clr     = flush_i || (en_i != st_q.en);
        st_d    = st_q;
        st_d.en = en_i;
        if (clr) begin
            st_d.hval = 1'b0;
        end else if (!en_i) begin
            if (wr_i) begin
                st_d.hold = wr_data_i;
                st_d.hval = 1'b1;
            end else if (rd_i) begin
                st_d.hval = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .push_req_i (en_i && wr_i),
        .pop_req_i  (en_i && rd_i),
        .wptr_o     (wptr),
        .rptr_o     (rptr),
        .cnt_o      (cnt),
        .push_o     (push),
        .ovf_o      (ovf_o)
    );

    rxq_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (push),
        .waddr_i (wptr),
        .wdata_i (wr_data_i),
        .raddr_i (rptr),
        .rdata_o (q_data)
    );

    rxq_level #(.DEPTH(DEPTH)) u_level (
        .trig_i (trig_i),
        .cnt_i  (cnt),
        .irq_o  (lvl_irq)
    );

    assign rd_data_o = st_q.en ? q_data : st_q.hold;
    assign fill_o    = st_q.en ? cnt : {{(CW-1){1'b0}}, st_q.hval};
    assign irq_o     = st_q.en ? lvl_irq : st_q.hval;

    p_irq_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en && fill_o == '0 |-> !irq_o);
    p_bypass_newest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i && !st_q.en && wr_i && !flush_i |=> rd_data_o == $past(wr_data_i) && fill_o == CW'(1));
    p_mode_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en_i != st_q.en |=> fill_o == '0 && !ovf_o);
endmodule

// File: tb/tb_rxq_fifo.sv
module tb_rxq_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, flush = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0] wdat = '0;
    logic [3:0] trig = '0;
    logic [7:0] rd_data;
    logic [3:0] fill;
    logic       irq, ovf;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // scoreboard model
    logic [7:0] exp_q[$];
    bit         m_en = 0, m_ovf = 0, m_hval = 0;
    logic [7:0] m_hold = '0;

    always #5 clk = ~clk;

    rxq_fifo dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .flush_i(flush), .wr_i(wr),
        .wr_data_i(wdat), .rd_i(rd), .trig_i(trig), .rd_data_o(rd_data),
        .fill_o(fill), .irq_o(irq), .ovf_o(ovf)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        int eff, ef, ei;
        eff = (trig == 0) ? 1 : (trig > 8) ? 8 : int'(trig);
        ef  = m_en ? exp_q.size() : int'(m_hval);
        ei  = m_en ? int'(ef >= eff) : int'(m_hval);
        chk(fill == ef, {tag, " fill"}, fill, ef);
        chk(irq == ei, {tag, " irq"}, irq, ei);
        chk(ovf == m_ovf, {tag, " ovf"}, ovf, m_ovf);
    endtask

    // driver + monitor: one cycle, starting and ending at a falling edge
    task automatic cyc(input bit w, input logic [7:0] dv, input bit r, input bit f, input string tag);
        if (r && !f) begin
            if (m_en && exp_q.size() > 0)
                chk(rd_data == exp_q[0], "R3 order", rd_data, exp_q[0]);
            else if (!m_en && m_hval)
                chk(rd_data == m_hold, "R9 held byte", rd_data, m_hold);
        end
        wr = w; wdat = dv; rd = r; flush = f;
        if (f) begin
            exp_q.delete(); m_ovf = 0; m_hval = 0;
        end else if (m_en) begin
            if (r && exp_q.size() > 0) void'(exp_q.pop_front());
            if (w) begin
                if (exp_q.size() < 8) exp_q.push_back(dv);
                else m_ovf = 1;
            end
        end else begin
            if (w) begin m_hold = dv; m_hval = 1; end
            else if (r) m_hval = 0;
        end
        @(negedge clk);
        wr = 0; rd = 0; flush = 0;
        check_outputs(tag);
    endtask

    task automatic set_en(input bit v);
        en = v;
        if (v != m_en) begin
            exp_q.delete(); m_ovf = 0; m_hval = 0;
        end
        m_en = v;
        @(negedge clk);
        check_outputs("R10 mode change");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R11 reset");

        set_en(1);
        trig = 4;
        for (int i = 0; i < 3; i++) cyc(1, 8'h10 + 8'(i), 0, 0, "R4 below trigger");
        cyc(1, 8'h13, 0, 0, "R4 reach trigger");
        for (int i = 4; i < 8; i++) cyc(1, 8'h10 + 8'(i), 0, 0, "R1 R2 fill");
        cyc(1, 8'hEE, 0, 0, "R6 write when full");
        cyc(1, 8'hEF, 0, 0, "R6 second drop");
        for (int i = 0; i < 8; i++) cyc(0, 8'h00, 1, 0, "R6 R3 drain");
        cyc(0, 8'h00, 1, 0, "R12 read empty");
        cyc(1, 8'h55, 0, 0, "R12 write after empty read");
        cyc(0, 8'h00, 1, 0, "R12 order kept");
        cyc(0, 8'h00, 0, 1, "R8 flush clears ovf");

        // threshold clamping
        trig = 0;
        cyc(1, 8'hA0, 0, 0, "R5 zero as one");
        trig = 15;
        @(negedge clk); check_outputs("R5 high clamp at 1");
        for (int i = 1; i < 7; i++) cyc(1, 8'hA0 + 8'(i), 0, 0, "R5 high clamp filling");
        cyc(1, 8'hA7, 1, 0, "R7 read+write at 7");
        cyc(1, 8'hA8, 0, 0, "R5 high clamp full");
        trig = 8;
        @(negedge clk); check_outputs("R5 trig eight");
        cyc(1, 8'hA9, 1, 0, "R7 read+write full");
        cyc(0, 8'h00, 1, 0, "R4 drop below eight");
        cyc(1, 8'hB0, 1, 1, "R8 flush priority");
        cyc(1, 8'hB1, 1, 0, "R12 write with read on empty");
        cyc(0, 8'h00, 1, 0, "R3 single");

        // pass-through
        trig = 4;
        cyc(1, 8'hC1, 0, 0, "R2 queued one");
        set_en(0);
        cyc(1, 8'hC2, 0, 0, "R9 load");
        cyc(1, 8'hC3, 0, 0, "R9 overwrite");
        cyc(0, 8'h00, 1, 0, "R9 read");
        cyc(0, 8'h00, 1, 0, "R9 read empty");
        cyc(1, 8'hC4, 0, 0, "R9 reload");
        cyc(0, 8'h00, 0, 1, "R8 flush bypass");
        cyc(1, 8'hC5, 0, 0, "R9 reload again");
        set_en(1);
        cyc(1, 8'hD0, 0, 0, "R10 queued after switch");
        cyc(0, 8'h00, 1, 0, "R10 read after switch");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule